// File: doc/BRIEF.md
# Prioritized Access Permission Checker

This block decides whether one memory access may proceed, given a table of already-decoded protection regions. A request carries a byte address, an access size, the set of permissions the access needs (read, write, execute) and whether the requester runs in machine mode. The block walks the region table from entry 0 upward, and the first entry that the access touches settles the answer. An access that straddles the edge of a region is refused at that entry. Machine-mode requests ignore an entry's permission bits unless the entry is locked.

Region bounds arrive as inclusive start and end byte addresses per entry, together with a small configuration field per entry. Turning the programmed address registers into bounds is done elsewhere, and so is turning a refusal into a trap. Requests and answers travel over a valid/ready pair on each side. The answer is registered, with room for one answer in flight.

Top module: `pmp_access_check`

## Requirements
- R1: `reqReady` is high whenever `respValid` is low or `respReady` is high. After a request is accepted, `respValid` is high in the following cycle. While `respValid` is high and `respReady` is low, `respValid` and `respAllow` hold their values.
- R2: The configuration field of each entry is 6 bits: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), and bit 5 lock. An entry in mode 0 takes no part in the scan, even when its bounds cover the access.
- R3: When every entry is in mode 0, every request is allowed in both privilege modes.
- R4: The last byte of an access is the address plus 2^`reqSize` minus 1. It is computed one bit wider than the address, so it never wraps. An entry matches when both the first and the last byte lie within its inclusive bounds.
- R5: When exactly one of the first and last bytes lies within an active entry, the request is denied and no later entry is looked at.
- R6: Entries are scanned from index 0 upward, and only the lowest-indexed active entry that the access touches decides the result.
- R7: On a match in machine mode with an unlocked entry, read, write and execute are all granted.
- R8: An entry counts as locked when its own lock bit is set, or when the next entry has its lock bit set and is in top-of-range mode. On a match with a locked entry, or on any match outside machine mode, only the entry's own read/write/execute bits are granted.
- R9: On a match, the request is allowed only if every bit set in `reqPerm` (bit 0 read, bit 1 write, bit 2 execute) is also granted.
- R10: When at least one entry is active and none is touched, machine-mode requests are allowed and other requests are denied.
- R11: After reset, `respValid` is low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken |
| reqAddr | input | ADDR_W | Byte address of the first byte |
| reqSize | input | 2 | Size code: access is 2^code bytes |
| reqPerm | input | 3 | Needed permissions: bit 0 read, bit 1 write, bit 2 execute |
| reqMachine | input | 1 | Requester runs in machine mode |
| respValid | output | 1 | Answer present |
| respReady | input | 1 | Answer is taken |
| respAllow | output | 1 | 1 = access allowed, 0 = denied |
| regionLo | input | ENTRIES*ADDR_W | Inclusive start byte of each entry, entry 0 in the low bits |
| regionHi | input | ENTRIES*ADDR_W | Inclusive end byte of each entry |
| regionCfg | input | ENTRIES*6 | Configuration field of each entry |

## Verification
The bench sweeps addresses from eight below to two above every region edge, over all sizes, all permission sets and both privilege modes, for four region tables. The tables cover overlapping entries, an off entry spanning the whole space, lock bits passed on by a top-of-range neighbour, and a region at the very top of the address space. Each of these targets a specific fault:
- Letting a later overlapping entry win, or not stopping at a straddling access, gives allows where a deny is due.
- Checking only the first byte admits accesses that straddle a region edge.
- A last byte that wraps near the top of the address space matches a region it should not.
- Missing the neighbour's lock flips the machine-mode answer.

Backpressure on the answer side checks that a held answer stays unchanged.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } regionMode_e;

  // bit 5 lock, bits 4:3 mode, bit 2 execute, bit 1 write, bit 0 read
  typedef struct packed {
    logic        lock;
    regionMode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entryCfg_t;

  localparam int CFG_W = $bits(entryCfg_t);

  typedef struct packed {
    logic loadResult;
  } ctrlStrobe_t;

endpackage

// File: rtl/pmp_chk_entry.sv
module pmp_chk_entry
  import pmp_chk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] firstByte,
  input  logic [ADDR_W:0]   lastByte,
  input  entryCfg_t         cfg,
  input  logic              nextTorLock,
  input  logic              machine,
  output logic              active,
  output logic              fullHit,
  output logic              partHit,
  output logic [2:0]        granted
);

  logic firstIn;
  logic lastIn;
  logic locked;

  assign active  = (cfg.mode != MODE_OFF);
  assign firstIn = (firstByte >= lo) && (firstByte <= hi);
  assign lastIn  = (lastByte >= {1'b0, lo}) && (lastByte <= {1'b0, hi});
  assign fullHit = active && firstIn && lastIn;
  assign partHit = active && (firstIn != lastIn);
  assign locked  = cfg.lock || nextTorLock;

  always_comb begin
    if (machine && !locked) granted = 3'b111;
    else                    granted = {cfg.x, cfg.w, cfg.r};
  end

endmodule

// File: rtl/pmp_chk_datapath.sv
module pmp_chk_datapath
  import pmp_chk_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqSize,
  input  logic [2:0]                reqPerm,
  input  logic                      reqMachine,
  input  logic [ENTRIES*ADDR_W-1:0] regionLo,
  input  logic [ENTRIES*ADDR_W-1:0] regionHi,
  input  logic [ENTRIES*CFG_W-1:0]  regionCfg,
  output logic                      respAllow
);

  localparam int LAST_W = ADDR_W + 1;

  entryCfg_t          cfgArr [ENTRIES];
  logic [ENTRIES-1:0] activeVec;
  logic [ENTRIES-1:0] fullVec;
  logic [ENTRIES-1:0] partVec;
  logic [2:0]         grantArr [ENTRIES];
  logic [LAST_W-1:0]  lastByte;
  logic [3:0]         sizeMinus1;
  logic               decision;

  assign sizeMinus1 = (4'd1 << reqSize) - 4'd1;
  assign lastByte   = {1'b0, reqAddr} + LAST_W'(sizeMinus1);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic nextTorLock;
    assign cfgArr[g] = regionCfg[g*CFG_W +: CFG_W];
    if (g + 1 < ENTRIES) begin : g_mid
      assign nextTorLock = regionCfg[(g+1)*CFG_W + CFG_W - 1]
                        && (regionCfg[(g+1)*CFG_W + 3 +: 2] == MODE_TOR);
    end else begin : g_top
      assign nextTorLock = 1'b0;
    end
    pmp_chk_entry #(.ADDR_W(ADDR_W)) u_entry (
      .lo          (regionLo[g*ADDR_W +: ADDR_W]),
      .hi          (regionHi[g*ADDR_W +: ADDR_W]),
      .firstByte   (reqAddr),
      .lastByte    (lastByte),
      .cfg         (cfgArr[g]),
      .nextTorLock (nextTorLock),
      .machine     (reqMachine),
      .active      (activeVec[g]),
      .fullHit     (fullVec[g]),
      .partHit     (partVec[g]),
      .granted     (grantArr[g])
    );
  end

  // first touched entry wins; fallback depends on whether any rule exists
  always_comb begin
    logic found;
    found    = 1'b0;
    decision = (|activeVec) ? reqMachine : 1'b1;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && (fullVec[i] || partVec[i])) begin
        found    = 1'b1;
        decision = fullVec[i] && ((reqPerm & ~grantArr[i]) == 3'b000);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  respAllow <= 1'b0;
    else if (strobe.loadResult) respAllow <= decision;
  end

  // R3: no active entry means the next answer is an allow
  a_r3_open_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult && (activeVec == '0) |=> respAllow);

  // R5: a straddle on entry 0 is always a deny
  a_r5_partial_denies: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult && partVec[0] |=> !respAllow);

  // R10: rules exist, nothing touched, machine mode -> allow
  a_r10_machine_default: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult && reqMachine && (activeVec != '0)
      && (fullVec == '0) && (partVec == '0) |=> respAllow);

  // R10: rules exist, nothing touched, lower mode -> deny
  a_r10_user_default: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult && !reqMachine && (activeVec != '0)
      && (fullVec == '0) && (partVec == '0) |=> !respAllow);

endmodule

// File: rtl/pmp_chk_ctrl.sv
module pmp_chk_ctrl
  import pmp_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        respValid,
  input  logic        respReady,
  output ctrlStrobe_t strobe
);

  assign reqReady          = !respValid || respReady;
  assign strobe.loadResult = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (!rstN)                  respValid <= 1'b0;
    else if (strobe.loadResult) respValid <= 1'b1;
    else if (respReady)         respValid <= 1'b0;
  end

  // R1: an accepted request produces an answer next cycle
  a_r1_valid_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> respValid);

endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check
  import pmp_chk_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  output logic                      reqReady,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [1:0]                reqSize,
  input  logic [2:0]                reqPerm,
  input  logic                      reqMachine,
  output logic                      respValid,
  input  logic                      respReady,
  output logic                      respAllow,
  input  logic [ENTRIES*ADDR_W-1:0] regionLo,
  input  logic [ENTRIES*ADDR_W-1:0] regionHi,
  input  logic [ENTRIES*CFG_W-1:0]  regionCfg
);

  ctrlStrobe_t strobe;

  pmp_chk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .respValid (respValid),
    .respReady (respReady),
    .strobe    (strobe)
  );

  pmp_chk_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqPerm    (reqPerm),
    .reqMachine (reqMachine),
    .regionLo   (regionLo),
    .regionHi   (regionHi),
    .regionCfg  (regionCfg),
    .respAllow  (respAllow)
  );

  // R1: a stalled answer does not change
  a_r1_resp_hold: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respReady |=> respValid && $stable(respAllow));

endmodule

// File: tb/pmp_access_check_bench.sv
module pmp_access_check_bench;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic [2:0] reqPerm = '0;
  logic reqMachine = 1'b0;
  logic respValid, respAllow;
  logic respReady = 1'b1;
  logic [N*AW-1:0] loFlat, hiFlat;
  logic [N*CW-1:0] cfgFlat;

  logic [AW-1:0] lo [N];
  logic [AW-1:0] hi [N];
  logic [CW-1:0] cfg [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      loFlat[i*AW +: AW]  = lo[i];
      hiFlat[i*AW +: AW]  = hi[i];
      cfgFlat[i*CW +: CW] = cfg[i];
    end
  end

  pmp_access_check #(.ENTRIES(N), .ADDR_W(AW)) u_pmp_access_check (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqPerm(reqPerm),
    .reqMachine(reqMachine), .respValid(respValid), .respReady(respReady),
    .respAllow(respAllow), .regionLo(loFlat), .regionHi(hiFlat),
    .regionCfg(cfgFlat)
  );

  function automatic logic [CW-1:0] mk(bit lk, int mode, bit x, bit w, bit r);
    return {lk, 2'(mode), x, w, r};
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected answer worked out from the requirements
  function automatic bit model(logic [AW-1:0] a, logic [1:0] sz, logic [2:0] pm,
                               bit mach, output string tag);
    int first, last, lim;
    bit anyActive, sawOff, s, e, locked, later;
    logic [2:0] g;
    first = int'(a);
    last  = first + (1 << sz) - 1;
    lim   = (1 << AW) - 1;
    anyActive = 1'b0; sawOff = 1'b0;
    for (int i = 0; i < N; i++) if (cfg[i][4:3] != 2'd0) anyActive = 1'b1;
    if (!anyActive) begin tag = "R3"; return 1'b1; end
    for (int i = 0; i < N; i++) begin
      s = (first >= int'(lo[i])) && (first <= int'(hi[i]));
      e = (last  >= int'(lo[i])) && (last  <= int'(hi[i]));
      if (cfg[i][4:3] == 2'd0) begin
        if (s) sawOff = 1'b1;
        continue;
      end
      if (s != e) begin tag = (last > lim) ? "R4" : "R5"; return 1'b0; end
      if (s) begin
        locked = cfg[i][5] ||
                 ((i + 1 < N) && cfg[(i+1)%N][5] && cfg[(i+1)%N][4:3] == 2'd1);
        g = (mach && !locked) ? 3'b111 : cfg[i][2:0];
        later = 1'b0;
        for (int j = i + 1; j < N; j++)
          if (cfg[j][4:3] != 2'd0 && first >= int'(lo[j]) && last <= int'(hi[j]))
            later = 1'b1;
        if (later)      tag = "R6";
        else if (!mach) tag = "R9";
        else            tag = locked ? "R8" : "R7";
        return (pm & ~g) == 3'b000;
      end
    end
    tag = sawOff ? "R2" : "R10";
    return mach;
  endfunction

  task automatic doReq(logic [AW-1:0] a, logic [1:0] sz, logic [2:0] pm, bit mach);
    string tag;
    bit exp;
    @(negedge clk);
    reqAddr = a; reqSize = sz; reqPerm = pm; reqMachine = mach; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    exp = model(a, sz, pm, mach, tag);
    check(respValid === 1'b1, "R1", int'(respValid), 1);
    check(respAllow === exp, tag, int'(respAllow), int'(exp));
  endtask

  task automatic sweep();
    logic [AW-1:0] a;
    for (int i = 0; i < N; i++)
      for (int side = 0; side < 2; side++)
        for (int d = -8; d <= 2; d++) begin
          a = AW'((side == 0 ? int'(lo[i]) : int'(hi[i])) + d);
          for (int sz = 0; sz < 4; sz++)
            for (int pm = 0; pm < 8; pm++)
              for (int m = 0; m < 2; m++)
                doReq(a, 2'(sz), 3'(pm), m[0]);
        end
  endtask

  task automatic loadC(bit allOff);
    lo[0] = 16'h0200; hi[0] = 16'h027F; cfg[0] = mk(0, allOff ? 0 : 1, 0, 1, 1);
    lo[1] = 16'h0280; hi[1] = 16'h02FF; cfg[1] = mk(1, allOff ? 0 : 1, 0, 0, 1);
    lo[2] = 16'h0300; hi[2] = 16'h030F; cfg[2] = mk(0, allOff ? 0 : 2, 0, 0, 0);
    lo[3] = 16'h0800; hi[3] = 16'h08FF; cfg[3] = mk(0, allOff ? 0 : 3, 1, 1, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    loadC(1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(respValid === 1'b0, "R11", int'(respValid), 0);
    check(reqReady === 1'b1, "R11", int'(reqReady), 1);

    // table A: everything off
    sweep();

    // table B: overlap, off entry spanning everything, locked entries
    lo[0] = 16'h0100; hi[0] = 16'h01FF; cfg[0] = mk(0, 1, 0, 0, 1);
    lo[1] = 16'h01F0; hi[1] = 16'h020F; cfg[1] = mk(1, 2, 0, 1, 1);
    lo[2] = 16'h0000; hi[2] = 16'hFFFF; cfg[2] = mk(0, 0, 1, 1, 1);
    lo[3] = 16'h0400; hi[3] = 16'h043F; cfg[3] = mk(1, 3, 1, 0, 0);
    sweep();

    // R1: backpressure holds the answer and blocks new requests
    respReady = 1'b0;
    @(negedge clk);
    reqAddr = 16'h0100; reqSize = 2'd0; reqPerm = 3'b001; reqMachine = 1'b0;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(respValid === 1'b1 && respAllow === 1'b1, "R1", int'(respAllow), 1);
    reqAddr = 16'h01FE; reqSize = 2'd2;
    check(reqReady === 1'b0, "R1", int'(reqReady), 0);
    @(posedge clk);
    @(negedge clk);
    check(respValid === 1'b1 && respAllow === 1'b1, "R1", int'(respAllow), 1);
    respReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(respValid === 1'b1 && respAllow === 1'b0, "R5", int'(respAllow), 0);
    @(negedge clk);
    check(respValid === 1'b0, "R1", int'(respValid), 0);

    // table C: lock carried from a top-of-range neighbour
    loadC(1'b0);
    sweep();

    // table D: region at the top of the address space
    lo[0] = 16'h0000; hi[0] = 16'h000F; cfg[0] = mk(0, 0, 1, 1, 1);
    lo[1] = 16'h0010; hi[1] = 16'h0013; cfg[1] = mk(0, 2, 0, 1, 0);
    lo[2] = 16'h0020; hi[2] = 16'h003F; cfg[2] = mk(0, 0, 0, 0, 0);
    lo[3] = 16'hFFF8; hi[3] = 16'hFFFF; cfg[3] = mk(1, 3, 0, 1, 1);
    sweep();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule